// File: doc/BRIEF.md
# Third-Order Cascaded Sigma-Delta Divide-Ratio Generator

This block produces a new division ratio on every reference clock for the multi-modulus divider of a fractional-N frequency synthesizer. Three first-order accumulator stages are chained. The first stage integrates a FRAC_W-bit fractional word. Each later stage integrates the low FRAC_W bits left over in the stage before it, in the same cycle. Every stage emits a one-bit overflow carry.

A noise-cancelling network merges the three carry streams into one small signed correction: c1 + (1−z⁻¹)c2 + (1−z⁻¹)²c3. The block adds that correction to a programmable integer divisor. Over time the divide ratio then averages int_div + frac_word/2^FRAC_W, and the quantization error is pushed to high frequencies with a third-order slope.

With a 40 MHz reference, integer settings from about 110 to 140 cover the oscillator tuning range. The fractional word sets the spacing between channels.

Top module: `mash111_divgen`

## Requirements
- R1: When `en` is high, the first-stage accumulator adds `frac_word` modulo 2^FRAC_W on every rising clock edge. Its carry c1 is 1 exactly in the cycles where the current accumulator value plus `frac_word` reaches 2^FRAC_W or more.
- R2: In the same cycle, the second stage adds the first stage's truncated FRAC_W-bit sum to its own register, producing carry c2. The third stage adds the second stage's truncated sum in the same way, producing carry c3.
- R3: The correction equals c1 + (c2 + c3 − c3_prev) − t_prev. Here c3_prev is c3 from the previous enabled cycle, and t_prev is the previous enabled cycle's value of (c2 + c3 − c3_prev). The correction always lies in −3..+4.
- R4: When `en` is high, `div_out` equals `int_div` plus the sign-extended correction, modulo 2^INT_W.
- R5: A synchronous active-high `rst` clears all three accumulators and both difference-delay registers. In the first cycle after reset, `div_out` equals `int_div` for any `frac_word`.
- R6: While `en` is low, `div_out` equals `int_div` and no internal state changes. When `en` returns high, the sequence resumes exactly where it stopped.
- R7: With `frac_word` = 0, `div_out` stays at `int_div` on every cycle after reset.
- R8: Over the first 2^FRAC_W enabled cycles after reset, the sum of (`div_out` − `int_div`) is within 2 of `frac_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the modulator; when low, hold state and output the integer divisor |
| frac_word | input | FRAC_W | Fractional part of the divide ratio, in units of 2^-FRAC_W |
| int_div | input | INT_W | Integer part of the divide ratio |
| div_out | output | INT_W | Instantaneous divide ratio for this cycle |

## Verification
The hardest condition to reach is the second difference term at its extremes. That needs a c3 transition to line up with a c2 change in one cycle and the opposite pattern in the cycle before. None of this can be seen at the ports, because only the merged sum comes out. The stimulus therefore runs whole 2^FRAC_W-cycle periods from reset for fractional words spread over the range: tiny, near one half, near full scale, and irregular. A cycle-accurate model built from the stage equations is compared against `div_out` on every cycle. The model is also compared across an enable pause, which confirms that the difference delays freeze together with the accumulators.

// File: rtl/mash111_divgen.sv
module mash111_divgen #(
  parameter int FRAC_W = 8,
  parameter int INT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [FRAC_W-1:0] frac_word,
  input  logic [INT_W-1:0]  int_div,
  output logic [INT_W-1:0]  div_out
);

  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc1, acc2, acc3;
  logic [SUM_W-1:0]  sum1, sum2, sum3;
  logic              c1, c2, c3, c3_q;
  logic signed [1:0] d3;
  logic signed [2:0] t_now, t_q;
  logic signed [3:0] d2, corr;

  assign sum1 = {1'b0, acc1} + {1'b0, frac_word};
  assign sum2 = {1'b0, acc2} + {1'b0, sum1[FRAC_W-1:0]};
  assign sum3 = {1'b0, acc3} + {1'b0, sum2[FRAC_W-1:0]};
  assign c1 = sum1[FRAC_W];
  assign c2 = sum2[FRAC_W];
  assign c3 = sum3[FRAC_W];

  assign d3    = $signed({1'b0, c3}) - $signed({1'b0, c3_q});
  assign t_now = $signed({2'b00, c2}) + $signed({d3[1], d3});
  assign d2    = $signed({t_now[2], t_now}) - $signed({t_q[2], t_q});
  assign corr  = d2 + $signed({3'b000, c1});

  assign div_out = en ? int_div + {{(INT_W-4){corr[3]}}, corr} : int_div;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc1 <= '0;
      acc2 <= '0;
      acc3 <= '0;
      c3_q <= 1'b0;
      t_q  <= '0;
    end else if (en) begin
      acc1 <= sum1[FRAC_W-1:0];
      acc2 <= sum2[FRAC_W-1:0];
      acc3 <= sum3[FRAC_W-1:0];
      c3_q <= c3;
      t_q  <= t_now;
    end
  end

  // R3: correction confined to -3..+4
  p_corr_range_r3: assert property (@(posedge clk) disable iff (rst)
    en |-> (corr >= -4'sd3 && corr <= 4'sd4));

  // R5: reset clears every state register
  p_reset_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc1 == '0 && acc2 == '0 && acc3 == '0 && !c3_q && t_q == '0));

  // R6: no state moves while disabled
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(acc1) && $stable(acc2) && $stable(acc3) && $stable(c3_q) && $stable(t_q)));

  // R1: first stage steps by the fractional word
  p_acc1_step_r1: assert property (@(posedge clk) disable iff (rst)
    en |=> acc1 == FRAC_W'($past(acc1) + $past(frac_word)));

endmodule

// File: tb/mash111_divgen_bench.sv
module mash111_divgen_bench;
  localparam int FW = 8;
  localparam int IW = 8;
  localparam int PERIOD = 1 << FW;

  logic clk = 1'b0;
  logic rst, en;
  logic [FW-1:0] frac_word;
  logic [IW-1:0] int_div;
  logic [IW-1:0] div_out;

  int checks = 0;
  int fails  = 0;
  int m1, m2, m3, mc3q, mtq;

  always #5 clk = ~clk;

  mash111_divgen #(.FRAC_W(FW), .INT_W(IW)) u_mash111_divgen (
    .clk(clk), .rst(rst), .en(en), .frac_word(frac_word),
    .int_div(int_div), .div_out(div_out));

  localparam logic [15:0] VEC [6] = '{
    {8'd1,   8'd110}, {8'd128, 8'd125}, {8'd255, 8'd140},
    {8'd85,  8'd120}, {8'd3,   8'd111}, {8'd200, 8'd133}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_corr(input int f);
    int s1, s2, s3, c1, c2, c3, t;
    s1 = m1 + f;                 c1 = s1 >> FW;
    s2 = m2 + (s1 % PERIOD);     c2 = s2 >> FW;
    s3 = m3 + (s2 % PERIOD);     c3 = s3 >> FW;
    t = c2 + c3 - mc3q;
    return c1 + t - mtq;
  endfunction

  task automatic model_adv(input int f);
    int s1, s2, s3, c2, c3;
    s1 = m1 + f;
    s2 = m2 + (s1 % PERIOD);     c2 = s2 >> FW;
    s3 = m3 + (s2 % PERIOD);     c3 = s3 >> FW;
    mtq = c2 + c3 - mc3q;
    mc3q = c3;
    m1 = s1 % PERIOD; m2 = s2 % PERIOD; m3 = s3 % PERIOD;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m1 = 0; m2 = 0; m3 = 0; mc3q = 0; mtq = 0;
  endtask

  // one enabled cycle: returns correction seen, mismatch flag
  task automatic run_cycle(output int seen, output int bad, output int range_bad);
    int exp;
    exp = (int'(int_div) + model_corr(int'(frac_word))) % (1 << IW);
    #1;
    seen = int'(div_out) - int'(int_div);
    if (seen > 127) seen -= 256;
    if (seen < -128) seen += 256;
    bad = (int'(div_out) != exp);
    range_bad = (seen < -3 || seen > 4);
    @(posedge clk);
    model_adv(int'(frac_word));
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b1; frac_word = '0; int_div = 8'd110;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R5 R8
    foreach (VEC[i]) begin
      int sum, mism, rbad, seen, bad, rb;
      frac_word = VEC[i][15:8];
      int_div   = VEC[i][7:0];
      do_reset();
      #1;
      check("R5 first output after reset", int'(div_out), int'(int_div));
      sum = 0; mism = 0; rbad = 0;
      for (int k = 0; k < PERIOD; k++) begin
        run_cycle(seen, bad, rb);
        sum += seen; mism += bad; rbad += rb;
      end
      check("R1 R2 R4 per-cycle divide sequence mismatches", mism, 0);
      check("R3 correction out of -3..+4 count", rbad, 0);
      check("R8 period sum within 2 of frac_word",
            (sum - int'(frac_word) <= 2 && sum - int'(frac_word) >= -2) ? 1 : 0, 1);
    end

    // R7: zero fraction gives constant integer divisor
    begin
      int nonint, seen, bad, rb;
      frac_word = '0; int_div = 8'd137;
      do_reset();
      nonint = 0;
      for (int k = 0; k < 40; k++) begin
        run_cycle(seen, bad, rb);
        nonint += (seen != 0);
      end
      check("R7 zero fraction cycles off integer", nonint, 0);
    end

    // R6: pause mid-sequence, output pinned, resume exactly
    begin
      int seen, bad, rb, mism, offv;
      frac_word = 8'd77; int_div = 8'd118;
      do_reset();
      mism = 0;
      for (int k = 0; k < 23; k++) begin
        run_cycle(seen, bad, rb);
        mism += bad;
      end
      en = 1'b0;
      offv = 0;
      for (int k = 0; k < 9; k++) begin
        #1;
        offv += (div_out != int_div);
        @(posedge clk); @(negedge clk);
      end
      check("R6 output equals int_div while disabled", offv, 0);
      en = 1'b1;
      for (int k = 0; k < 100; k++) begin
        run_cycle(seen, bad, rb);
        mism += bad;
      end
      check("R6 sequence resumes where it stopped", mism, 0);
    end

    // R5: reset mid-run with a large fraction
    begin
      int seen, bad, rb;
      frac_word = 8'd250; int_div = 8'd140;
      do_reset();
      for (int k = 0; k < 17; k++) run_cycle(seen, bad, rb);
      do_reset();
      #1;
      check("R5 mid-run reset returns to int_div", int'(div_out), 140);
      run_cycle(seen, bad, rb);
      check("R1 second cycle after reset follows model", bad, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule